// File: doc/BRIEF.md
# Square-Wave Tone Channel Bank

The bank holds three square-wave tone generators that share one prescaled tick and a mixer. Each generator has a 10-bit half-period and counts it down one step per tick. When the count runs out, its output bit flips and the count reloads from the current period input. The mixer takes the three tone bits and one noise bit supplied from outside. It turns each channel's 4-bit attenuation code into an amplitude through a fixed logarithmic table and adds the amplitudes of the channels whose bit is high. It produces a mono sum and left and right sums, with a mask that routes each channel to either side.

The period, attenuation and routing values come straight from a register file that sits outside this block. The noise generator is also a separate block, and it drives the noise bit. Parameters set three things: the prescale ratio, how a period of zero is treated, and whether the outputs leave the block negated. A one-cycle strobe marks every cycle in which the mixed outputs carry a new sample.

Top module: `sqt_bank`

## Requirements
- R1: While reset is high and in the first cycle after it falls, every tone bit is 0, all three sample outputs are 0 and the strobe is low.
- R2: `sample_valid_o` is high for exactly one cycle out of every PRESCALE clock cycles (default 8, alternate configuration 1). After reset is released, the first strobe appears PRESCALE rising edges later.
- R3: For a nonzero period P, a tone bit holds each level for exactly P ticks, which is P×PRESCALE clock cycles. The period is read at each reload, so a new value applies from the next flip onward.
- R4: With ZERO_IS_MAX=1 (default), a period of 0 holds each level for 1024 ticks.
- R5: With ZERO_IS_MAX=0, a period of 0 flips the tone bit on every tick.
- R6: Attenuation code k maps to the amplitude trunc(8191 × 10^(−k/10)) for k in 0..14, and code 15 maps to 0. Code 0 therefore gives one quarter of 0x7FFF.
- R7: `mix_o` is the sum over channels 0..3 of the amplitude of the channel's code when its bit is 1. Channels 0..2 are the tone bits, and channel 3 is `noise_i` with code `attn_i[3]`. The tone bits used are those produced on the same tick. The output changes only on the edge that raises the strobe and holds at all other times.
- R8: `left_o` adds only the channels c for which `pan_i[4+c]` is 1, and `right_o` adds only those for which `pan_i[c]` is 1.
- R9: With NEGATE=1, all three sample outputs are the arithmetic negation of the sums described in R7 and R8.
- R10: After reset, every counter starts at zero, so every tone bit is 1 after the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 3×10 | Half-period per tone channel, in ticks |
| attn_i | input | 4×4 | Attenuation code per channel; index 3 belongs to the noise bit |
| noise_i | input | 1 | Noise bit from the external generator |
| pan_i | input | 8 | Bits 7..4 route channels 3..0 to the left; bits 3..0 route them to the right |
| tone_o | output | 3 | Current level of each tone channel |
| sample_valid_o | output | 1 | One-cycle strobe that marks a new sample |
| mix_o | output | 16 | Signed mono sample |
| left_o | output | 16 | Signed left sample |
| right_o | output | 16 | Signed right sample |

## Verification
The hardest conditions to reach from the ports are the long half-period cases: a period of 1023, and a zero period under the default rule. Each needs thousands of clock cycles before a second flip shows up. The bench reaches them by changing the period and letting one flip pass, so that the reload has picked up the new value. It then times the gap between the next two flips. The mixer is swept through all sixteen codes on every channel, with a changing routing mask and a noise bit that changes every cycle. Each strobed sample is compared against amplitudes the bench derives with real arithmetic from the tone bits that are visible at the time.

// File: rtl/sqt_pkg.sv
package sqt_pkg;

    localparam int AMP_W  = 13;
    localparam int ATTN_W = 4;

    // 2 dB per code step starting at 0x7FFF/4, truncated; last code is silent
    function automatic logic [AMP_W-1:0] amp_lookup(input logic [ATTN_W-1:0] code);
        logic [AMP_W-1:0] a;
        unique case (code)
            4'd0:    a = 13'd8191;
            4'd1:    a = 13'd6506;
            4'd2:    a = 13'd5168;
            4'd3:    a = 13'd4105;
            4'd4:    a = 13'd3260;
            4'd5:    a = 13'd2590;
            4'd6:    a = 13'd2057;
            4'd7:    a = 13'd1634;
            4'd8:    a = 13'd1298;
            4'd9:    a = 13'd1031;
            4'd10:   a = 13'd819;
            4'd11:   a = 13'd650;
            4'd12:   a = 13'd516;
            4'd13:   a = 13'd410;
            4'd14:   a = 13'd326;
            default: a = 13'd0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/sqt_prescaler.sv
module sqt_prescaler #(
    parameter int PRESCALE = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(PRESCALE - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == '0) s_d.cnt = RELOAD;
        else               s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.cnt <= RELOAD;
        else     s_q     <= s_d;
    end

    assign tick_o = (s_q.cnt == '0);

endmodule

// File: rtl/sqt_tone_chan.sv
module sqt_tone_chan #(
    parameter int PERIOD_W    = 10,
    parameter int ZERO_IS_MAX = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                tone_o,
    output logic                tone_nxt_o
);
    localparam int CNT_W = PERIOD_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             tone;
    } chan_t;

    chan_t            s_d, s_q;
    logic [CNT_W-1:0] zero_val;
    logic [CNT_W-1:0] reload;

    generate
        if (ZERO_IS_MAX != 0) begin : g_zero_max
            assign zero_val = CNT_W'(1) << PERIOD_W;
        end else begin : g_zero_fast
            assign zero_val = '0;
        end
    endgenerate

    assign reload = (period_i == '0) ? zero_val : CNT_W'(period_i);

    always_comb begin
        s_d = s_q;
        if (tick_i) begin
            if (s_q.count <= CNT_W'(1)) begin
                s_d.tone  = ~s_q.tone;
                s_d.count = reload;
            end else begin
                s_d.count = s_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.count <= '0;
            s_q.tone  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tone_o     = s_q.tone;
    assign tone_nxt_o = s_d.tone;

endmodule

// File: rtl/sqt_mixer.sv
module sqt_mixer
    import sqt_pkg::*;
#(
    parameter int NUM_TONE = 3,
    parameter int OUT_W    = 16,
    parameter int NEGATE   = 0
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                tick_i,
    input  logic [NUM_TONE-1:0]                 tone_nxt_i,
    input  logic                                noise_i,
    input  logic [NUM_TONE:0][ATTN_W-1:0]       attn_i,
    input  logic [2*(NUM_TONE+1)-1:0]           pan_i,
    output logic                                valid_o,
    output logic signed [OUT_W-1:0]             mix_o,
    output logic signed [OUT_W-1:0]             left_o,
    output logic signed [OUT_W-1:0]             right_o
);
    localparam int NUM_CH = NUM_TONE + 1;
    localparam int SUM_W  = AMP_W + $clog2(NUM_CH);

    typedef struct packed {
        logic                    valid;
        logic signed [OUT_W-1:0] mix;
        logic signed [OUT_W-1:0] left;
        logic signed [OUT_W-1:0] right;
    } mix_t;

    mix_t s_d, s_q;

    function automatic logic signed [OUT_W-1:0] shape(input logic [SUM_W-1:0] sum);
        logic signed [OUT_W-1:0] v;
        v = $signed(OUT_W'(sum));
        if (NEGATE != 0) v = -v;
        return v;
    endfunction

    logic [NUM_CH-1:0] ch_on;
    assign ch_on = {noise_i, tone_nxt_i};

    always_comb begin
        logic [SUM_W-1:0] sum_all;
        logic [SUM_W-1:0] sum_l;
        logic [SUM_W-1:0] sum_r;
        logic [AMP_W-1:0] amp;
        s_d     = s_q;
        s_d.valid = tick_i;
        sum_all = '0;
        sum_l   = '0;
        sum_r   = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            amp = ch_on[c] ? amp_lookup(attn_i[c]) : '0;
            sum_all = sum_all + SUM_W'(amp);
            if (pan_i[NUM_CH + c]) sum_l = sum_l + SUM_W'(amp);
            if (pan_i[c])          sum_r = sum_r + SUM_W'(amp);
        end
        if (tick_i) begin
            s_d.mix   = shape(sum_all);
            s_d.left  = shape(sum_l);
            s_d.right = shape(sum_r);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.valid <= 1'b0;
            s_q.mix   <= '0;
            s_q.left  <= '0;
            s_q.right <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o = s_q.valid;
    assign mix_o   = s_q.mix;
    assign left_o  = s_q.left;
    assign right_o = s_q.right;

endmodule

// File: rtl/sqt_bank.sv
module sqt_bank
    import sqt_pkg::*;
#(
    parameter int PRESCALE    = 8,
    parameter int ZERO_IS_MAX = 1,
    parameter int NEGATE      = 0,
    parameter int NUM_TONE    = 3,
    parameter int PERIOD_W    = 10,
    parameter int OUT_W       = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_TONE-1:0][PERIOD_W-1:0]   period_i,
    input  logic [NUM_TONE:0][ATTN_W-1:0]       attn_i,
    input  logic                                noise_i,
    input  logic [2*(NUM_TONE+1)-1:0]           pan_i,
    output logic [NUM_TONE-1:0]                 tone_o,
    output logic                                sample_valid_o,
    output logic signed [OUT_W-1:0]             mix_o,
    output logic signed [OUT_W-1:0]             left_o,
    output logic signed [OUT_W-1:0]             right_o
);
    logic                tick;
    logic [NUM_TONE-1:0] tone_nxt;

    sqt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    generate
        for (genvar g = 0; g < NUM_TONE; g++) begin : g_chan
            sqt_tone_chan #(
                .PERIOD_W    (PERIOD_W),
                .ZERO_IS_MAX (ZERO_IS_MAX)
            ) u_chan (
                .clk        (clk),
                .rst        (rst),
                .tick_i     (tick),
                .period_i   (period_i[g]),
                .tone_o     (tone_o[g]),
                .tone_nxt_o (tone_nxt[g])
            );
        end
    endgenerate

    sqt_mixer #(
        .NUM_TONE (NUM_TONE),
        .OUT_W    (OUT_W),
        .NEGATE   (NEGATE)
    ) u_mix (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .tone_nxt_i (tone_nxt),
        .noise_i    (noise_i),
        .attn_i     (attn_i),
        .pan_i      (pan_i),
        .valid_o    (sample_valid_o),
        .mix_o      (mix_o),
        .left_o     (left_o),
        .right_o    (right_o)
    );

endmodule

// File: rtl/sqt_bank_chk.sv
module sqt_bank_chk #(
    parameter int PRESCALE = 8,
    parameter int NEGATE   = 0,
    parameter int NUM_TONE = 3,
    parameter int OUT_W    = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_TONE-1:0]     tone_o,
    input logic                    sample_valid_o,
    input logic signed [OUT_W-1:0] mix_o,
    input logic signed [OUT_W-1:0] left_o,
    input logic signed [OUT_W-1:0] right_o
);
    int   gap_q;
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (sample_valid_o) begin
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1;
        end
    end

    function automatic int mag(input logic signed [OUT_W-1:0] v);
        return (v < 0) ? -int'(v) : int'(v);
    endfunction

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tone_o == '0 && mix_o == '0 && !sample_valid_o));

    // R2
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_valid_o && seen_q) |-> (gap_q == PRESCALE - 1));

    // R3
    tone_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tone_o) |-> sample_valid_o);

    // R7
    mix_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_valid_o |-> ($stable(mix_o) && $stable(left_o) && $stable(right_o)));

    // R8
    side_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid_o |-> (mag(left_o) <= mag(mix_o) && mag(right_o) <= mag(mix_o)));

    // R9
    sign_chk: assert property (@(posedge clk) disable iff (rst)
        (NEGATE != 0) ? (mix_o <= 0) : (mix_o >= 0));

endmodule

bind sqt_bank sqt_bank_chk #(
    .PRESCALE (PRESCALE),
    .NEGATE   (NEGATE),
    .NUM_TONE (NUM_TONE),
    .OUT_W    (OUT_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .tone_o         (tone_o),
    .sample_valid_o (sample_valid_o),
    .mix_o          (mix_o),
    .left_o         (left_o),
    .right_o        (right_o)
);

// File: tb/sqt_bank_tb.sv
module sqt_bank_tb;
    localparam int NT = 3;
    localparam int NC = 4;
    localparam int PW = 10;
    localparam int OW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NT-1:0][PW-1:0] period;
    logic [NC-1:0][3:0]    attn;
    logic                  noise;
    logic [7:0]            pan;

    logic [NT-1:0]         tone, a_tone;
    logic                  valid, a_valid;
    logic signed [OW-1:0]  mix, left_s, right_s, a_mix, a_left, a_right;

    sqt_bank u_dut (
        .clk(clk), .rst(rst), .period_i(period), .attn_i(attn), .noise_i(noise),
        .pan_i(pan), .tone_o(tone), .sample_valid_o(valid), .mix_o(mix),
        .left_o(left_s), .right_o(right_s)
    );

    sqt_bank #(.PRESCALE(1), .ZERO_IS_MAX(0), .NEGATE(1)) u_alt (
        .clk(clk), .rst(rst), .period_i(period), .attn_i(attn), .noise_i(noise),
        .pan_i(pan), .tone_o(a_tone), .sample_valid_o(a_valid), .mix_o(a_mix),
        .left_o(a_left), .right_o(a_right)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  mix_chk_en = 1'b0;
    bit  done = 1'b0;
    int  amp_tab[16];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // inputs as the mixer saw them at the latching edge
    logic [NC-1:0][3:0] s_attn;
    logic               s_noise;
    logic [7:0]         s_pan;
    always @(posedge clk) begin
        s_attn  <= attn;
        s_noise <= noise;
        s_pan   <= pan;
    end

    function automatic int exp_sum(input logic [NT-1:0] t, input int side);
        int s = 0;
        logic [NC-1:0] on;
        on = {s_noise, t};
        for (int c = 0; c < NC; c++) begin
            if (on[c]) begin
                if (side == 0 || (side == 1 && s_pan[NC + c]) || (side == 2 && s_pan[c]))
                    s += amp_tab[s_attn[c]];
            end
        end
        return s;
    endfunction

    int prev_mix = 0;
    always @(negedge clk) begin
        if (mix_chk_en) begin
            if (valid) begin
                check(int'(mix) == exp_sum(tone, 0), "R6 R7 mono", int'(mix), exp_sum(tone, 0));
                check(int'(left_s) == exp_sum(tone, 1), "R8 left", int'(left_s), exp_sum(tone, 1));
                check(int'(right_s) == exp_sum(tone, 2), "R8 right", int'(right_s), exp_sum(tone, 2));
            end else begin
                check(int'(mix) == prev_mix, "R7 hold", int'(mix), prev_mix);
            end
            if (a_valid) begin
                check(int'(a_mix) == -exp_sum(a_tone, 0), "R9 mono", int'(a_mix), -exp_sum(a_tone, 0));
                check(int'(a_left) == -exp_sum(a_tone, 1), "R9 left", int'(a_left), -exp_sum(a_tone, 1));
                check(int'(a_right) == -exp_sum(a_tone, 2), "R9 right", int'(a_right), -exp_sum(a_tone, 2));
            end
        end
        prev_mix = int'(mix);
    end

    task automatic wait_flip(input int ch, input bit alt, output int t);
        logic start;
        start = alt ? a_tone[ch] : tone[ch];
        forever begin
            @(negedge clk);
            if ((alt ? a_tone[ch] : tone[ch]) != start) break;
        end
        t = cyc;
    endtask

    task automatic measure(input int ch, input bit alt, input int exp, input string req);
        int t0, t1;
        wait_flip(ch, alt, t0);
        wait_flip(ch, alt, t0);
        wait_flip(ch, alt, t1);
        check((t1 - t0) == exp, req, t1 - t0, exp);
    endtask

    initial begin
        real v;
        int  c0, c1;
        v = 8191.0;
        for (int i = 0; i < 15; i++) begin
            amp_tab[i] = $rtoi(v);
            v = v / 1.258925412;
        end
        amp_tab[15] = 0;

        period = {10'd3, 10'd3, 10'd3};
        attn   = '1;
        noise  = 1'b0;
        pan    = 8'hFF;

        repeat (4) @(negedge clk);
        check(tone == '0 && a_tone == '0, "R1 tones", int'(tone), 0);
        check(mix == 0 && a_mix == 0, "R1 mix", int'(mix), 0);
        check(!valid && !a_valid, "R1 strobe", int'(valid), 0);

        rst = 1'b0;
        c0 = cyc;
        @(negedge clk);
        check(a_valid == 1'b1, "R2 alt first strobe", int'(a_valid), 1);
        check(a_tone == 3'b111, "R10 alt first tick", int'(a_tone), 7);
        check(tone == '0 && mix == 0 && !valid, "R1 after release", int'(tone), 0);
        while (!valid) @(negedge clk);
        check((cyc - c0) == 8, "R2 first strobe", cyc - c0, 8);
        check(tone == 3'b111, "R10 first tick", int'(tone), 7);
        c1 = cyc;
        @(negedge clk);
        check(!valid, "R2 one-cycle strobe", int'(valid), 0);
        while (!valid) @(negedge clk);
        check((cyc - c1) == 8, "R2 strobe spacing", cyc - c1, 8);
        mix_chk_en = 1'b1;

        // R3 period sweep on the default and alternate configurations
        period[0] = 10'd1;  measure(0, 0, 8, "R3 P=1");
        period[0] = 10'd2;  measure(0, 0, 16, "R3 P=2");
        period[0] = 10'd7;  measure(0, 0, 56, "R3 P=7");
        measure(0, 1, 7, "R3 alt P=7");
        period[1] = 10'd100; measure(1, 0, 800, "R3 P=100");
        period[2] = 10'd1023; measure(2, 0, 8184, "R3 P=1023");
        period[2] = 10'd5;  measure(2, 1, 5, "R3 alt P=5");

        // zero-period rules
        period[1] = 10'd0;
        measure(1, 0, 8192, "R4 zero period");
        measure(1, 1, 1, "R5 alt zero period");

        // mixer sweep over every code, routing pattern and a moving noise bit
        period = {10'd3, 10'd2, 10'd1};
        for (int a = 0; a < 16; a++) begin
            for (int c = 0; c < NC; c++) attn[c] = 4'(a + 5 * c);
            pan = 8'(a * 37 + 11);
            for (int k = 0; k < 32; k++) begin
                @(negedge clk);
                noise = ((a + k) % 3) == 0;
            end
        end
        attn = {4'd15, 4'd15, 4'd15, 4'd0};
        repeat (40) @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule